// File: doc/BRIEF.md
# Address Region Attribute Matcher

This block checks a 32-bit physical address against eight programmable address windows. It returns the memory-attribute bits of the window that contains the address. A separate register file holds, for each window, a 24-bit descriptor and an 8-bit attribute byte. The block reads them as flat vectors.

The descriptor holds the window size code in bits 3:0 and the window base (address bits 31:12) in bits 23:4. The window size is a power of two chosen by the code. Window 7 counts in units 64 times coarser than the other windows. A single global enable turns all matching off.

When several windows contain the address, the lowest-numbered window wins. When no window contains it, the block raises a miss flag and drives every attribute low. The address-to-attribute path is combinational. A parameter can add one output register stage.

Top module: `region_attr_match`

## Requirements
- R1: An address lies in window r when its bits 31:12, masked to the window size, equal descriptor bits 23:4 under the same mask. The six attribute outputs then take bits 5:0 of that window's attribute byte and `miss` is 0.
- R2: Size code 0 (descriptor bits 3:0) disables a window, so it never matches.
- R3: For windows 0 to 6, size code c from 1 to 14 covers 4 KB × 2^(c−1) bytes. The window starts at the base rounded down to that size. The byte just past its end does not match, and neither does the byte just before its start.
- R4: For window 7, size code c from 1 to 14 covers 256 KB × 2^(c−1) bytes. Code 1 is 256 KB and code 14 is 2 GB.
- R5: Size code 15 covers the whole 4 GB space for every window.
- R6: Base bits that fall inside the window size are ignored.
- R7: While `glb_en` is 0, no window matches. `miss` is 1 and all attribute outputs are 0.
- R8: When more than one window matches, the lowest-numbered one supplies the attributes.
- R9: When no window matches, `miss` is 1 and all six attribute outputs are 0.
- R10: Attribute byte bits map to outputs as follows: bit 0 `cache_dis`, bit 1 `weak_wo`, bit 2 `weak_lock`, bit 3 `wr_gather`, bit 4 `wr_thru`, bit 5 `lbus_supp`. Bits 7:6 have no effect.
- R11: With REG_OUT=0, the outputs follow the inputs in the same cycle. With REG_OUT=1, they show the result for the inputs of the previous clock edge, and a synchronous reset sets `miss`=1 with all attributes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (output register stage and checks) |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global matching enable |
| addr | input | 32 | Physical address to classify |
| region_cfg | input | 192 | Eight 24-bit descriptors, window r at bits 24r+23:24r |
| region_attr | input | 64 | Eight attribute bytes, window r at bits 8r+7:8r |
| cache_dis | output | 1 | Caching disabled for the address |
| weak_wo | output | 1 | Weak write ordering |
| weak_lock | output | 1 | Weak locking |
| wr_gather | output | 1 | Write gathering allowed |
| wr_thru | output | 1 | Write-through |
| lbus_supp | output | 1 | Local-bus signal suppressed |
| miss | output | 1 | No window contains the address |

## Verification
The assertions check these properties on every cycle:
- A window with code 0 never reports a hit.
- A code-15 window always hits while enabled.
- A cleared global enable forces a miss.
- A miss carries all-zero attributes.
- The priority logic grants at most one window, and only a window that hit.
- The registered variant repeats the previous cycle's combinational result.

Only the bench's scenarios can show that the window edges fall on the right bytes for each size scale, that low base bits are masked, that the lowest window wins an overlap, and that each attribute bit reaches its own output.

// File: rtl/region_attr_pkg.sv
// region_attr_pkg: shared widths, the attribute bundle and the size-mask
// helper for the address region attribute matcher.
// Assumes a 32-bit physical address split into a 4 KB page offset and a
// 20-bit page number.
package region_attr_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int BASE_W     = ADDR_W - PAGE_SHIFT;
    localparam int SIZE_W     = 4;
    localparam int CFG_W      = BASE_W + SIZE_W;
    localparam int ATTR_W     = 8;
    localparam int NATTR      = 6;

    localparam logic [SIZE_W-1:0] CODE_OFF = '0;
    localparam logic [SIZE_W-1:0] CODE_ALL = '1;

    // Attribute bundle: the first member is the most significant bit (bit 5),
    // so bit 0 of the attribute byte lands on cache_dis.
    typedef struct packed {
        logic lbus_supp;
        logic wr_thru;
        logic wr_gather;
        logic weak_lock;
        logic weak_wo;
        logic cache_dis;
    } attr_t;

    // Returns the page-number bits that take part in the compare for a size code.
    // extra widens the size scale by 2^extra.
    function automatic logic [BASE_W-1:0] keep_mask(input logic [SIZE_W-1:0] code,
                                                    input int unsigned       extra);
        int unsigned k;
        logic [BASE_W-1:0] m;
        if (code == CODE_ALL)      k = BASE_W;
        else if (code == CODE_OFF) k = 0;
        else                       k = int'(code) - 1 + extra;
        if (k > BASE_W) k = BASE_W;
        for (int i = 0; i < BASE_W; i++) begin
            m[i] = (i >= int'(k));
        end
        return m;
    endfunction

endpackage

// File: rtl/region_decode.sv
// region_decode: hit detector for one address window.
// Compares the page number with the descriptor base under the size mask.
// EXTRA_SHIFT widens the size scale (6 gives the coarse window).
// Assumes the descriptor layout {base[19:0], size_code[3:0]}.
module region_decode
    import region_attr_pkg::*;
#(
    parameter int unsigned EXTRA_SHIFT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BASE_W-1:0] page,
    input  logic [CFG_W-1:0]  cfg,
    output logic              hit
);

    logic [SIZE_W-1:0] code;
    logic [BASE_W-1:0] base;
    logic [BASE_W-1:0] mask;

    // Split the descriptor and derive the compare mask.
    always_comb begin
        code = cfg[SIZE_W-1:0];
        base = cfg[CFG_W-1:SIZE_W];
        mask = keep_mask(code, EXTRA_SHIFT);
    end

    // Window hit: enabled, size code non-zero, masked page equals masked base.
    always_comb begin
        hit = en && (code != CODE_OFF) && (((page ^ base) & mask) == '0);
    end

    // R2
    off_code_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[SIZE_W-1:0] == CODE_OFF) |-> !hit);

    // R5
    full_code_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg[SIZE_W-1:0] == CODE_ALL) |-> hit);

    // R7
    disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !hit);

endmodule

// File: rtl/region_pick.sv
// region_pick: fixed-priority selection among window hits.
// The lowest-numbered hitting window supplies its attribute byte.
// Assumes attribute bytes are packed with window r at bits 8r+7:8r.
// Bits 7:6 of each byte are not used.
module region_pick
    import region_attr_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        hit_vec,
    input  logic [NREG*ATTR_W-1:0] attr_flat,
    output attr_t                  sel_attr,
    output logic                   miss
);

    logic [NREG-1:0]   grant;
    logic [NREG*2-1:0] unused_attr_hi;

    // One-hot grant to the lowest-numbered window that hit.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit_vec[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // AND-OR mux of the granted attribute byte; no grant gives zero.
    always_comb begin
        logic [NATTR-1:0] acc;
        acc = '0;
        for (int i = 0; i < NREG; i++) begin
            acc |= attr_flat[i*ATTR_W +: NATTR] & {NATTR{grant[i]}};
        end
        sel_attr = attr_t'(acc);
        miss     = (grant == '0);
    end

    // Collect the top two bits of each attribute byte, which are not used.
    for (genvar g = 0; g < NREG; g++) begin : g_hi
        assign unused_attr_hi[g*2 +: 2] = attr_flat[g*ATTR_W+NATTR +: 2];
    end

    // R8
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    grant_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~hit_vec) == '0);

endmodule

// File: rtl/region_out_stage.sv
// region_out_stage: optional output register for the match result.
// With REG_OUT=0 it is a straight wire. With REG_OUT=1 it is one register
// with a synchronous active-low reset to "miss, no attributes".
module region_out_stage
    import region_attr_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  attr_t in_attr,
    input  logic  in_miss,
    output attr_t out_attr,
    output logic  out_miss
);

    if (REG_OUT) begin : g_reg
        // Capture the combinational result each cycle; reset shows a miss.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_attr <= '0;
                out_miss <= 1'b1;
            end else begin
                out_attr <= in_attr;
                out_miss <= in_miss;
            end
        end

        // R11
        reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (out_attr == $past(in_attr) && out_miss == $past(in_miss)));
    end else begin : g_wire
        assign out_attr = in_attr;
        assign out_miss = in_miss;
    end

endmodule

// File: rtl/region_attr_match.sv
// region_attr_match: eight-window address attribute matcher (top).
// Decodes every window in parallel, picks the lowest-numbered hit and drives
// its attribute bits, optionally through one register stage.
// Assumes descriptors and attribute bytes are held stable by an external
// register file.
module region_attr_match
    import region_attr_pkg::*;
#(
    parameter int          NREG         = 8,
    parameter int          COARSE_IDX   = 7,
    parameter int unsigned COARSE_SHIFT = 6,
    parameter bit          REG_OUT      = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glb_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NREG*CFG_W-1:0]  region_cfg,
    input  logic [NREG*ATTR_W-1:0] region_attr,
    output logic                   cache_dis,
    output logic                   weak_wo,
    output logic                   weak_lock,
    output logic                   wr_gather,
    output logic                   wr_thru,
    output logic                   lbus_supp,
    output logic                   miss
);

    logic [BASE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] unused_addr_lo;
    logic [NREG-1:0]       hit_vec;
    attr_t                 pick_attr;
    logic                  pick_miss;
    attr_t                 q_attr;
    logic                  q_miss;

    assign page           = addr[ADDR_W-1:PAGE_SHIFT];
    assign unused_addr_lo = addr[PAGE_SHIFT-1:0];

    // One decoder per window; the coarse window gets the wider size scale.
    for (genvar g = 0; g < NREG; g++) begin : g_win
        localparam int unsigned SHIFT = (g == COARSE_IDX) ? COARSE_SHIFT : 0;
        region_decode #(.EXTRA_SHIFT(SHIFT)) u_dec (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (glb_en),
            .page (page),
            .cfg  (region_cfg[g*CFG_W +: CFG_W]),
            .hit  (hit_vec[g])
        );
    end

    region_pick #(.NREG(NREG)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vec  (hit_vec),
        .attr_flat(region_attr),
        .sel_attr (pick_attr),
        .miss     (pick_miss)
    );

    region_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_attr (pick_attr),
        .in_miss (pick_miss),
        .out_attr(q_attr),
        .out_miss(q_miss)
    );

    // Fan the attribute bundle out to the named ports.
    always_comb begin
        cache_dis = q_attr.cache_dis;
        weak_wo   = q_attr.weak_wo;
        weak_lock = q_attr.weak_lock;
        wr_gather = q_attr.wr_gather;
        wr_thru   = q_attr.wr_thru;
        lbus_supp = q_attr.lbus_supp;
        miss      = q_miss;
    end

    // R7
    global_off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> pick_miss);

    // R9
    miss_zero_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_miss |-> (pick_attr == '0));

    // R9
    hit_clears_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> !pick_miss);

endmodule

// File: tb/region_attr_match_bench.sv
// Bench for region_attr_match.
// A behavioural byte-range model predicts every lookup. The model is
// compared with a combinational instance in the same cycle and with a
// registered instance one clock later.
module region_attr_match_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         glb_en = 1'b0;
    logic [31:0]  addr = '0;
    logic [23:0]  cfg_a [NREG];
    logic [7:0]   att_a [NREG];
    logic [191:0] cfg_flat;
    logic [63:0]  att_flat;

    logic c_cd, c_wo, c_wl, c_wg, c_wt, c_lb, c_miss;
    logic r_cd, r_wo, r_wl, r_wg, r_wt, r_lb, r_miss;

    int checks = 0;
    int errors = 0;
    logic [6:0] q_exp [$];
    string      q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the descriptor and attribute arrays into the flat port vectors.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            cfg_flat[i*24 +: 24] = cfg_a[i];
            att_flat[i*8 +: 8]   = att_a[i];
        end
    end

    region_attr_match #(.REG_OUT(1'b0)) u_region_attr_match (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .addr(addr),
        .region_cfg(cfg_flat), .region_attr(att_flat),
        .cache_dis(c_cd), .weak_wo(c_wo), .weak_lock(c_wl), .wr_gather(c_wg),
        .wr_thru(c_wt), .lbus_supp(c_lb), .miss(c_miss)
    );

    region_attr_match #(.REG_OUT(1'b1)) u_region_attr_match_reg (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .addr(addr),
        .region_cfg(cfg_flat), .region_attr(att_flat),
        .cache_dis(r_cd), .weak_wo(r_wo), .weak_lock(r_wl), .wr_gather(r_wg),
        .wr_thru(r_wt), .lbus_supp(r_lb), .miss(r_miss)
    );

    // Reference model: windows as byte ranges, first containing window wins.
    // Result layout is {miss, attribute bits 5:0}.
    function automatic logic [6:0] model(input logic [31:0] a);
        longint sz, lo, base, av;
        av = longint'(a);
        if (!glb_en) return 7'b100_0000;
        for (int r = 0; r < NREG; r++) begin
            int code;
            code = int'(cfg_a[r][3:0]);
            if (code == 0) continue;
            if (code == 15) sz = 64'h1_0000_0000;
            else sz = 64'd4096 << (code - 1 + ((r == 7) ? 6 : 0));
            base = longint'({cfg_a[r][23:4], 12'h000});
            lo   = base - (base % sz);
            if (av >= lo && av < lo + sz) return {1'b0, att_a[r][5:0]};
        end
        return 7'b100_0000;
    endfunction

    task automatic check(input string tag, input string who,
                         input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s) addr=%h got=%b expected=%b", tag, who, addr, got, exp);
        end
    endtask

    // Compare the registered instance with the lookup pushed one edge earlier.
    always @(posedge clk) begin
        #1;
        if (rst_n && q_exp.size() > 0) begin
            check(q_tag.pop_front(), "registered R11",
                  {r_miss, r_lb, r_wt, r_wg, r_wl, r_wo, r_cd}, q_exp.pop_front());
        end
    end

    task automatic set_region(input int r, input logic [19:0] base,
                              input logic [3:0] code, input logic [7:0] att);
        @(negedge clk);
        cfg_a[r] = {base, code};
        att_a[r] = att;
    endtask

    task automatic step(input logic [31:0] a, input string tag);
        logic [6:0] e;
        @(negedge clk);
        addr = a;
        #1;
        e = model(a);
        check(tag, "comb", {c_miss, c_lb, c_wt, c_wg, c_wl, c_wo, c_cd}, e);
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < NREG; i++) begin
            cfg_a[i] = '0;
            att_a[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state of the registered variant
        check("R11", "reset", {r_miss, r_lb, r_wt, r_wg, r_wl, r_wo, r_cd}, 7'b100_0000);
        @(negedge clk);
        rst_n  = 1'b1;
        glb_en = 1'b1;

        // R9: nothing programmed, everything misses
        step(32'h0000_0000, "R9");
        step(32'hDEAD_BEEF, "R9");

        // R1 / R3: 8 KB window at 0x0010_0000, and 4 KB window at 0x0040_0000
        set_region(0, 20'h00100, 4'h2, 8'h01);
        set_region(1, 20'h00400, 4'h1, 8'h02);
        step(32'h0010_0800, "R1");
        step(32'h0040_0FFF, "R1");
        step(32'h0010_1FFF, "R3");
        step(32'h0010_2000, "R3");
        step(32'h000F_FFFF, "R3");
        step(32'h0040_1000, "R3");

        // R3: 32 MB window (code 14) on window 6
        set_region(6, 20'h04000, 4'hE, 8'h10);
        step(32'h05FF_FFFF, "R3");
        step(32'h0600_0000, "R3");

        // R4: coarse window 7, 256 KB then 2 GB
        set_region(7, 20'h08000, 4'h1, 8'h04);
        step(32'h0803_FFFF, "R4");
        step(32'h0804_0000, "R4");
        step(32'h07FF_FFFF, "R4");
        set_region(7, 20'h80000, 4'hE, 8'h04);
        step(32'h8000_0000, "R4");
        step(32'hFFFF_FFFF, "R4");
        step(32'h7FFF_FFFF, "R4");

        // R6: low base bits inside a 64 KB window are ignored
        set_region(2, 20'h12345, 4'h5, 8'h08);
        step(32'h1234_0000, "R6");
        step(32'h1234_FFFF, "R6");
        step(32'h1233_FFFF, "R6");

        // R2: turning window 1 off removes its hit
        set_region(1, 20'h00400, 4'h0, 8'h02);
        step(32'h0040_0010, "R2");

        // R10: walk each attribute bit and check that bits 7:6 do nothing
        for (int b = 0; b < 6; b++) begin
            set_region(0, 20'h00100, 4'h2, 8'h01 << b);
            step(32'h0010_0004, "R10");
        end
        set_region(0, 20'h00100, 4'h2, 8'hC0);
        step(32'h0010_0004, "R10");

        // R5 / R8: window 3 covers everything; lower window 0 still wins
        set_region(0, 20'h00100, 4'h2, 8'h21);
        set_region(3, 20'hABCDE, 4'hF, 8'h3E);
        step(32'h0000_0000, "R5");
        step(32'hFFFF_FFFF, "R5");
        step(32'h0010_0100, "R8");
        step(32'h1234_5678, "R8");

        // R7: global enable low masks all windows, including the 4 GB one
        @(negedge clk);
        glb_en = 1'b0;
        step(32'h0010_0100, "R7");
        step(32'h8000_0000, "R7");
        @(negedge clk);
        glb_en = 1'b1;

        // R1 / R8: random descriptors and addresses against the model
        for (int n = 0; n < 40; n++) begin
            for (int r = 0; r < NREG; r++) begin
                set_region(r, 20'($urandom), 4'($urandom), 8'($urandom));
            end
            for (int k = 0; k < 10; k++) begin
                step((k < 5) ? {cfg_a[k][23:4], 12'($urandom)} : $urandom, "R1");
            end
        end

        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule